// File: doc/BRIEF.md
# Unlock-Sequence Flash Bank Programmer

This block erases or programs one bank of a byte-wide flash device. The device accepts a command only after a two-write unlock key. It shows that an internal operation has finished when two back-to-back reads of the bank base return the same byte. A host hands the block one request: an erase or program flag and a bank index. For a program request, the host then streams the bank's contents in byte by byte on a valid/ready source channel. The block writes every key, command and data byte with a minimum quiet gap between write strobes. It polls for completion with a bounded number of read pairs. It leaves the device in read mode with a reset command and reads the bank back to verify the result.

The bank base address is the bank index times `BANK_STRIDE` (8192 by default). All magic offsets are added to that base. The flash port uses single-cycle strobes. Read data is taken one cycle after the read strobe. When the block finishes it raises `done` for one cycle. At that point `timed_out` and `verify_fail` describe the operation just finished. They keep those values until the next request is accepted.

Back-pressure rules: a request is taken in the cycle where both `req_valid` and `req_ready` are high. `req_ready` is high only while the block is idle. A source byte is taken in the cycle where both `src_valid` and `src_ready` are high. `src_ready` rises only when the sequencer needs the next program byte, so the host may hold `src_valid` low for any number of cycles. The source channel is never used for erase.

Top module: `uflash_bank_prog`

## Requirements
- R1: While reset is low and right after it, `busy`, `done`, `timed_out`, `verify_fail`, `fl_we`, `fl_oe` and `src_ready` are 0, and `req_ready` is 1.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. In the next cycle `busy` is 1 and both flags are 0. `req_ready` stays 0 while `busy` is 1, so a request offered during an operation is not taken.
- R3: Every command starts with the key 0xAA written to base+0x555, then 0x55 written to base+0x2AA, where base = bank × `BANK_STRIDE`.
- R4: An erase writes the key, then 0x80 to base+0x555, then the key again, then 0x30 to base+0x000.
- R5: A program writes, for each byte offset i from 0 up to `BANK_BYTES`-1 in ascending order: the key, then 0xA0 to base+0x555, then source byte i to base+i. Exactly one source byte is consumed per offset, through the valid/ready channel.
- R6: Between any two write strobes there are at least `GAP_CYC` cycles with `fl_we` low.
- R7: After the last write of a command and its gap, the block reads base twice in consecutive cycles. It treats the command as complete only when the two bytes are equal.
- R8: If `POLL_LIMIT` read pairs in a row differ, `timed_out` is set. A program then abandons the remaining bytes and consumes no further source bytes.
- R9: Every operation, whether it succeeds or times out, ends by writing 0xF0 to base+0x000, followed by a gap, before `done`.
- R10: After each programmed byte completes, the block reads base+i. If that byte differs from the source byte, `verify_fail` is set and programming continues.
- R11: After an erase that did not time out, and after its reset write, every byte of the bank is read back. Any byte other than 0xFF sets `verify_fail`.
- R12: `done` is a one-cycle pulse in the last busy cycle, and `busy` is 0 in the following cycle.
- R13: `fl_we` and `fl_oe` are never high together, and neither is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_erase | input | 1 | 1 = sector erase, 0 = program bank |
| req_bank | input | BANK_W | Bank index |
| src_valid | input | 1 | Source byte offered |
| src_ready | output | 1 | Sequencer wants the next program byte |
| src_data | input | 8 | Source byte |
| fl_addr | output | FA_W | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_oe | output | 1 | Flash read strobe; data returns next cycle |
| fl_rdata | input | 8 | Flash read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timed_out | output | 1 | Last operation exhausted its poll budget |
| verify_fail | output | 1 | Last operation failed read-back |

## Verification
The bench uses a behavioural flash model. The model rejects any write out of key or command order, counts quiet cycles between strobes, and returns toggling status bytes for a set number of reads after each command. Clean erases and programs on both banks, each with a different data seed, tell bank-base errors and byte-order errors apart from sequencing errors. A dropped program byte and an erase that leaves one byte non-blank exercise the two verify paths separately. A device that never settles drives the timeout path for both operations, which shows whether the remaining bytes are abandoned. A source channel that offers data only every third cycle, a request offered mid-operation, and a reset mid-program cover back-pressure, request blocking and recovery.

// File: rtl/uflash_pkg.sv
package uflash_pkg;

  localparam int MAGIC_W = 12;

  localparam logic [MAGIC_W-1:0] KEY_OFS_A = 12'h555;
  localparam logic [MAGIC_W-1:0] KEY_OFS_B = 12'h2AA;
  localparam logic [MAGIC_W-1:0] BASE_OFS  = 12'h000;

  localparam logic [7:0] KEY_VAL_A   = 8'hAA;
  localparam logic [7:0] KEY_VAL_B   = 8'h55;
  localparam logic [7:0] ERASE_ARM   = 8'h80;
  localparam logic [7:0] ERASE_GO    = 8'h30;
  localparam logic [7:0] PROG_ARM    = 8'hA0;
  localparam logic [7:0] READ_MODE   = 8'hF0;
  localparam logic [7:0] BLANK_BYTE  = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WRITE,
    ST_GAP,
    ST_POLL1,
    ST_POLL2,
    ST_POLL3,
    ST_CHK_RD,
    ST_CHK_CMP,
    ST_RST_WR,
    ST_RST_GAP,
    ST_SWP_RD,
    ST_SWP_CMP,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/uflash_cmd_table.sv
module uflash_cmd_table
  import uflash_pkg::*;
(
  input  logic               is_erase,
  input  logic [2:0]         step,
  output logic [MAGIC_W-1:0] step_ofs,
  output logic [7:0]         step_val,
  output logic               step_is_data,
  output logic               step_last
);

  always_comb begin
    step_ofs     = BASE_OFS;
    step_val     = 8'h00;
    step_is_data = 1'b0;
    step_last    = 1'b0;
    if (step == 3'd0) begin
      step_ofs = KEY_OFS_A;
      step_val = KEY_VAL_A;
    end else if (step == 3'd1) begin
      step_ofs = KEY_OFS_B;
      step_val = KEY_VAL_B;
    end else if (is_erase) begin
      case (step)
        3'd2: begin step_ofs = KEY_OFS_A; step_val = ERASE_ARM; end
        3'd3: begin step_ofs = KEY_OFS_A; step_val = KEY_VAL_A; end
        3'd4: begin step_ofs = KEY_OFS_B; step_val = KEY_VAL_B; end
        default: begin
          step_ofs  = BASE_OFS;
          step_val  = ERASE_GO;
          step_last = 1'b1;
        end
      endcase
    end else begin
      if (step == 3'd2) begin
        step_ofs = KEY_OFS_A;
        step_val = PROG_ARM;
      end else begin
        step_is_data = 1'b1;
        step_last    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/uflash_gap_timer.sv
module uflash_gap_timer #(
  parameter int GAP_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);

  localparam int CW = $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (start)
      cnt <= CW'(GAP_CYC - 1);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/uflash_toggle_poll.sv
module uflash_toggle_poll #(
  parameter int POLL_LIMIT = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       capture,
  input  logic       compare,
  input  logic [7:0] rdata,
  output logic       settled,
  output logic       exhausted
);

  localparam int AW = $clog2(POLL_LIMIT + 1);

  logic [7:0]    first_rd;
  logic [AW-1:0] tries;
  logic          same;

  assign same      = (first_rd == rdata);
  assign settled   = compare && same;
  assign exhausted = compare && !same && (tries == AW'(POLL_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_rd <= '0;
      tries    <= '0;
    end else begin
      if (capture)
        first_rd <= rdata;
      if (clear)
        tries <= '0;
      else if (compare && !same)
        tries <= tries + 1'b1;
    end
  end

endmodule

// File: rtl/uflash_bank_prog.sv
module uflash_bank_prog
  import uflash_pkg::*;
#(
  parameter int BANK_BYTES  = 8192,
  parameter int BANK_STRIDE = 8192,
  parameter int NUM_BANKS   = 2,
  parameter int GAP_CYC     = 100,
  parameter int POLL_LIMIT  = 1000000,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int OFS_W  = $clog2(BANK_STRIDE),
  localparam int FA_W   = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_erase,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [7:0]        src_data,
  output logic [FA_W-1:0]   fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_oe,
  input  logic [7:0]        fl_rdata,
  output logic              busy,
  output logic              done,
  output logic              timed_out,
  output logic              verify_fail
);

  localparam int IDX_W = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_BYTES - 1);

  seq_state_e        state;
  logic              is_erase;
  logic [BANK_W-1:0] bank;
  logic [IDX_W-1:0]  idx;
  logic [2:0]        step;
  logic [7:0]        hold;

  logic [MAGIC_W-1:0] c_ofs;
  logic [7:0]         c_val;
  logic               c_data;
  logic               c_last;
  logic               gap_start;
  logic               gap_done;
  logic               poll_ok;
  logic               poll_dead;

  logic [FA_W-1:0] base_addr;
  logic [FA_W-1:0] idx_addr;
  logic [FA_W-1:0] cmd_addr;

  uflash_cmd_table u_tab (
    .is_erase     (is_erase),
    .step         (step),
    .step_ofs     (c_ofs),
    .step_val     (c_val),
    .step_is_data (c_data),
    .step_last    (c_last)
  );

  assign gap_start = (state == ST_WRITE) || (state == ST_RST_WR);

  uflash_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (gap_start),
    .expired (gap_done)
  );

  uflash_toggle_poll #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (state == ST_WRITE),
    .capture   (state == ST_POLL2),
    .compare   (state == ST_POLL3),
    .rdata     (fl_rdata),
    .settled   (poll_ok),
    .exhausted (poll_dead)
  );

  assign base_addr = {bank, {OFS_W{1'b0}}};
  assign idx_addr  = base_addr + FA_W'(idx);
  assign cmd_addr  = base_addr + FA_W'(c_ofs);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      is_erase    <= 1'b0;
      bank        <= '0;
      idx         <= '0;
      step        <= '0;
      hold        <= '0;
      timed_out   <= 1'b0;
      verify_fail <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            is_erase    <= req_erase;
            bank        <= req_bank;
            idx         <= '0;
            step        <= '0;
            timed_out   <= 1'b0;
            verify_fail <= 1'b0;
            state       <= req_erase ? ST_WRITE : ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (src_valid) begin
            hold  <= src_data;
            step  <= '0;
            state <= ST_WRITE;
          end
        end
        ST_WRITE: state <= ST_GAP;
        ST_GAP: begin
          if (gap_done) begin
            if (c_last)
              state <= ST_POLL1;
            else begin
              step  <= step + 3'd1;
              state <= ST_WRITE;
            end
          end
        end
        ST_POLL1: state <= ST_POLL2;
        ST_POLL2: state <= ST_POLL3;
        ST_POLL3: begin
          if (poll_ok)
            state <= is_erase ? ST_RST_WR : ST_CHK_RD;
          else if (poll_dead) begin
            timed_out <= 1'b1;
            state     <= ST_RST_WR;
          end else
            state <= ST_POLL1;
        end
        ST_CHK_RD: state <= ST_CHK_CMP;
        ST_CHK_CMP: begin
          if (fl_rdata != hold)
            verify_fail <= 1'b1;
          if (idx == LAST_IDX)
            state <= ST_RST_WR;
          else begin
            idx   <= idx + 1'b1;
            state <= ST_FETCH;
          end
        end
        ST_RST_WR: state <= ST_RST_GAP;
        ST_RST_GAP: begin
          if (gap_done) begin
            if (is_erase && !timed_out) begin
              idx   <= '0;
              state <= ST_SWP_RD;
            end else
              state <= ST_DONE;
          end
        end
        ST_SWP_RD: state <= ST_SWP_CMP;
        ST_SWP_CMP: begin
          if (fl_rdata != BLANK_BYTE)
            verify_fail <= 1'b1;
          if (idx == LAST_IDX)
            state <= ST_DONE;
          else begin
            idx   <= idx + 1'b1;
            state <= ST_SWP_RD;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign src_ready = (state == ST_FETCH);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign fl_we     = (state == ST_WRITE) || (state == ST_RST_WR);
  assign fl_oe     = (state == ST_POLL1) || (state == ST_POLL2) ||
                     (state == ST_CHK_RD) || (state == ST_SWP_RD);

  always_comb begin
    fl_addr  = base_addr;
    fl_wdata = 8'h00;
    case (state)
      ST_WRITE: begin
        fl_addr  = c_data ? idx_addr : cmd_addr;
        fl_wdata = c_data ? hold : c_val;
      end
      ST_RST_WR: fl_wdata = READ_MODE;
      ST_CHK_RD, ST_SWP_RD: fl_addr = idx_addr;
      default: fl_addr = base_addr;
    endcase
  end

endmodule

// File: rtl/uflash_bank_prog_chk.sv
module uflash_bank_prog_chk #(
  parameter int GAP_CYC = 100
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic src_ready,
  input logic fl_we,
  input logic fl_oe,
  input logic busy,
  input logic done,
  input logic timed_out,
  input logic verify_fail
);

  localparam int QW = $clog2(GAP_CYC + 1) + 1;

  logic [QW-1:0] quiet;

  always_ff @(posedge clk) begin
    if (!rst_n)
      quiet <= QW'(GAP_CYC);
    else if (fl_we)
      quiet <= '0;
    else if (quiet < QW'(GAP_CYC))
      quiet <= quiet + 1'b1;
  end

  assert_accept_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !timed_out && !verify_fail));

  assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_src_in_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> busy);

  assert_write_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> (quiet >= QW'(GAP_CYC)));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_oe));

  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_we && !fl_oe));

endmodule

bind uflash_bank_prog uflash_bank_prog_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .src_ready   (src_ready),
  .fl_we       (fl_we),
  .fl_oe       (fl_oe),
  .busy        (busy),
  .done        (done),
  .timed_out   (timed_out),
  .verify_fail (verify_fail)
);

// File: tb/sim_uflash_bank_prog.sv
module sim_uflash_bank_prog;

  localparam int BB  = 16;
  localparam int GAP = 4;
  localparam int PL  = 8;
  localparam int NV  = 9;

  // vector: {erase, bank, seed[7:0], fault[1:0], exp_timeout, exp_verify_fail}
  // fault 0 none, 1 byte 5 program dropped, 2 byte 3 left 0x00 after erase, 3 never settles
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h00, 2'd0, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'h3C, 2'd0, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h00, 2'd0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'hA5, 2'd0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 2'd0, 1'b0, 1'b0},
    {1'b0, 1'b0, 8'h12, 2'd1, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h00, 2'd2, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'h5A, 2'd3, 1'b1, 1'b0},
    {1'b1, 1'b0, 8'h00, 2'd3, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_erase = 1'b0;
  logic [0:0]  req_bank = '0;
  logic        src_valid = 1'b0, src_ready;
  logic [7:0]  src_data = '0;
  logic [13:0] fl_addr;
  logic [7:0]  fl_wdata, fl_rdata = '0;
  logic        fl_we, fl_oe, busy, done, timed_out, verify_fail;

  uflash_bank_prog #(.BANK_BYTES(BB), .GAP_CYC(GAP), .POLL_LIMIT(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_bank(req_bank), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_oe(fl_oe), .fl_rdata(fl_rdata),
    .busy(busy), .done(done), .timed_out(timed_out), .verify_fail(verify_fail)
  );

  int nchk = 0, nfail = 0;

  function automatic logic [7:0] pat(input logic [7:0] sd, input int i);
    return sd ^ 8'(i * 37);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] mem [2][BB];
  logic [7:0] expm [2][BB];
  int  mseq = 0, mbusy = 0, quiet = 1000;
  bit  mstuck = 0, mtog = 0;
  int  seq_err = 0, gap_err = 0, rst_cnt = 0;
  int  fault = 0;
  int  wb, wo;

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < BB; i++) begin
        mem[b][i]  = 8'hFF;
        expm[b][i] = 8'hFF;
      end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mseq = 0; mbusy = 0; mstuck = 0; quiet = 1000;
    end else begin
      if (fl_we) begin
        if (quiet < GAP) gap_err++;
        quiet = 0;
        wb = int'(fl_addr[13]);
        wo = int'(fl_addr[12:0]);
        if (fl_wdata == 8'hF0 && wo == 0) begin
          mseq = 0; mbusy = 0; mstuck = 0; rst_cnt++;
        end else if (mbusy > 0 || mstuck) begin
          seq_err++;
        end else begin
          case (mseq)
            0: if (wo == 'h555 && fl_wdata == 8'hAA) mseq = 1; else begin seq_err++; mseq = 0; end
            1: if (wo == 'h2AA && fl_wdata == 8'h55) mseq = 2; else begin seq_err++; mseq = 0; end
            2: if (wo == 'h555 && fl_wdata == 8'h80) mseq = 3;
               else if (wo == 'h555 && fl_wdata == 8'hA0) mseq = 6;
               else begin seq_err++; mseq = 0; end
            3: if (wo == 'h555 && fl_wdata == 8'hAA) mseq = 4; else begin seq_err++; mseq = 0; end
            4: if (wo == 'h2AA && fl_wdata == 8'h55) mseq = 5; else begin seq_err++; mseq = 0; end
            5: begin
              if (wo == 0 && fl_wdata == 8'h30) begin
                for (int i = 0; i < BB; i++) mem[wb][i] = 8'hFF;
                if (fault == 2) mem[wb][3] = 8'h00;
                mbusy = 3; mstuck = (fault == 3);
              end else seq_err++;
              mseq = 0;
            end
            6: begin
              if (wo < BB) begin
                if (!(fault == 1 && wo == 5)) mem[wb][wo] = mem[wb][wo] & fl_wdata;
                mbusy = 3; mstuck = (fault == 3);
              end else seq_err++;
              mseq = 0;
            end
            default: mseq = 0;
          endcase
        end
      end else if (quiet < 1000) quiet++;
      if (fl_oe) begin
        if (mbusy > 0 || mstuck) begin
          mtog = ~mtog;
          fl_rdata <= {1'b0, mtog, 6'd0};
          if (mbusy > 0) mbusy--;
        end else if (int'(fl_addr[12:0]) < BB)
          fl_rdata <= mem[fl_addr[13]][fl_addr[12:0]];
        else
          fl_rdata <= 8'hFF;
      end
    end
  end

  // ---------------- source feeder ----------------
  int src_cnt = 0, s_base = 0, phase = 0;
  logic [7:0] cur_seed = '0;
  bit feed_stall = 0;

  always @(posedge clk)
    if (rst_n && src_valid && src_ready) src_cnt <= src_cnt + 1;

  always @(negedge clk) begin
    phase = (phase + 1) % 3;
    src_valid = feed_stall ? (phase == 0) : 1'b1;
    src_data  = pat(cur_seed, src_cnt - s_base);
  end

  // ---------------- operation task ----------------
  task automatic run_op(input bit er, input bit bk, input logic [7:0] sd, input int flt,
                        input bit xto, input bit xvf, input bit stall, input bit poke);
    int r0, e0, g0, w, n, mm;
    string rq;
    fault = flt; cur_seed = sd; feed_stall = stall;
    r0 = rst_cnt; e0 = seq_err; g0 = gap_err;
    rq = er ? "R4" : "R5";
    if (er) begin
      for (int i = 0; i < BB; i++) expm[bk][i] = 8'hFF;
      if (flt == 2) expm[bk][3] = 8'h00;
    end else begin
      n = xto ? 1 : BB;
      for (int i = 0; i < n; i++)
        if (!(flt == 1 && i == 5)) expm[bk][i] = expm[bk][i] & pat(sd, i);
    end
    @(negedge clk);
    s_base = src_cnt;
    req_erase = er; req_bank = bk; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !timed_out && !verify_fail, "R2", "accept gives busy, flags clear", int'(busy), 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      req_valid = 1'b1; req_bank = ~bk; req_erase = 1'b1;
      chk(req_ready == 1'b0, "R2", "ready low while busy", int'(req_ready), 0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    w = 0;
    while (!done && w < 40000) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R12", "done pulse seen", int'(done), 1);
    chk(timed_out == xto, "R8", "timeout flag", int'(timed_out), int'(xto));
    chk(verify_fail == xvf, er ? "R11" : "R10", "verify flag (R7 poll honoured)", int'(verify_fail), int'(xvf));
    chk(seq_err == e0, "R3", "unlock/command order errors", seq_err - e0, 0);
    chk(gap_err == g0, "R6", "write gap violations", gap_err - g0, 0);
    chk(rst_cnt == r0 + 1, "R9", "read-mode reset writes", rst_cnt - r0, 1);
    if (!er)
      chk(src_cnt - s_base == (xto ? 1 : BB), xto ? "R8" : "R5", "source bytes consumed",
          src_cnt - s_base, xto ? 1 : BB);
    if (!xto) begin
      mm = 0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < BB; i++)
          if (mem[b][i] != expm[b][i]) mm++;
      chk(mm == 0, rq, "bank image mismatches", mm, 0);
    end
    @(negedge clk);
    chk(!busy && !done, "R12", "idle after done", int'(busy), 0);
    if (poke) chk(!busy, "R2", "mid-op request not taken", int'(busy), 0);
    feed_stall = 0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (180000) @(posedge clk);
    nfail++;
    $display("FAIL R12 watchdog expired: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !timed_out && !verify_fail && !fl_we && !fl_oe && !src_ready && req_ready,
        "R1", "state during reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && req_ready && !fl_we && !fl_oe, "R1", "state after reset (R13 idle strobes)",
        int'(busy), 0);

    for (int v = 0; v < NV; v++)
      run_op(VEC[v][13], VEC[v][12], VEC[v][11:4], int'(VEC[v][3:2]), VEC[v][1], VEC[v][0], 1'b0, 1'b0);

    // back-pressure on the source channel, plus a request offered mid-operation
    run_op(1'b1, 1'b1, 8'h00, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_op(1'b0, 1'b1, 8'hC3, 0, 1'b0, 1'b0, 1'b1, 1'b1);

    // reset in the middle of a program
    run_op(1'b1, 1'b0, 8'h00, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    fault = 0; cur_seed = 8'h77;
    @(negedge clk);
    s_base = src_cnt;
    req_erase = 1'b0; req_bank = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !fl_we && !fl_oe && !src_ready && req_ready && !done, "R1", "mid-op reset returns idle",
        int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(1'b1, 1'b0, 8'h00, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_op(1'b0, 1'b0, 8'h77, 0, 1'b0, 1'b0, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule